// File: doc/BRIEF.md
# Dual-Width ALU with Status Flags

This block is an arithmetic logic unit for a small processor datapath. It takes two operands, an operation code and a width select. The width select chooses either the full 16-bit word or only its low byte. The unit computes a combinational result. When it is told to, it also captures six status flags in a register on the rising clock edge. Those flags are carry, parity, nibble carry, zero, sign and signed overflow.

The operations are addition, subtraction, AND, OR, XOR, increment, decrement, bitwise complement, and single-bit logical shifts left and right. Each class of operation has its own rule for setting the flags. Increment and decrement keep the carry flag. Logic operations clear carry, overflow and nibble carry. Shifts load the carry flag with the bit pushed out. Complement and unassigned codes never disturb the flag register. A surrounding sequencer drives `flag_we` to decide which instructions commit their flags.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment (a+1), 6 decrement (a-1), 7 complement (~a), 8 shift left by one, 9 logical shift right by one, and all other codes give a result of zero. With `wide`=0 only the low 8 operand bits are used and result bits 15:8 are zero.
- R2: The sign flag (`flags[4]`) takes the most significant bit of the result at the selected width.
- R3: The zero flag (`flags[3]`) is set exactly when the result at the selected width is zero.
- R4: The parity flag (`flags[1]`) is set when result bits 7:0 contain an even number of ones, in both widths.
- R5: For add, the carry flag (`flags[0]`) is the carry out of the top bit at the selected width. For subtract it is the borrow, meaning a < b unsigned.
- R6: The nibble carry flag (`flags[2]`) is the carry out of bit 3 for add and increment, and the borrow into bit 4 for subtract and decrement.
- R7: The overflow flag (`flags[5]`) is set for add, subtract, increment and decrement when the signed two's-complement result does not fit the selected width.
- R8: AND, OR and XOR clear the carry, overflow and nibble carry flags.
- R9: Increment and decrement leave the carry flag at its previous value and set the other five flags as add or subtract with an operand of 1.
- R10: A left shift puts the old top bit (at the selected width) into carry, and sets overflow to the new top bit XOR carry. A right shift puts the old bit 0 into carry, and sets overflow to the old top bit. Both shifts clear nibble carry.
- R11: The flag register changes only on a clock edge where `flag_we` is 1 and the code is 0-6, 8 or 9. Complement and unassigned codes leave all six flags unchanged.
- R12: On a clock edge with `rst_n` low, all six flags become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (add, subtract and logic only) |
| op_code | input | 4 | Operation select, encoding in R1 |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| flag_we | input | 1 | Commit flags of this operation on the next rising edge |
| result | output | 16 | Combinational result, masked to the selected width |
| flags | output | 6 | Registered flags: [0] carry, [1] parity, [2] nibble carry, [3] zero, [4] sign, [5] overflow |

## Verification
On every cycle the bound checker watches several things. It confirms that the flags hold when no write is enabled, and that complement never moves them. It checks that increment and decrement keep the carry, and that logic operations clear carry, overflow and nibble carry. It also checks that sign, zero and parity follow the result seen one cycle earlier, and that the upper byte is zero in 8-bit mode. Carry, borrow, nibble carry and signed overflow depend on the operand values themselves. Only the bench's sweeps can show those, comparing them against arithmetic done with integers in 8-bit and 16-bit modes, including values at the sign and nibble boundaries.

// File: rtl/alu_flags_pkg.sv
// Shared definitions for the dual-width ALU: operation codes and flag layout.
// Assumes a 4-bit operation code; codes without a name are treated as unassigned.
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } alu_op_e;

    localparam int FLAG_N = 6;

    // Packed so that cf is bit 0 and ovf is bit 5 of the flag vector.
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic nib;
        logic par;
        logic cry;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor producing the carry, nibble carry and signed overflow at the
// selected width. Assumes operand bits above the selected width are already zero.
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         wide,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         nib_carry,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W:0] full;
    logic       sa, sb, sr;

    // One extended-width add or subtract; the bit above the lane gives carry/borrow.
    always_comb begin
        if (sub) full = {1'b0, a} - {1'b0, b};
        else     full = {1'b0, a} + {1'b0, b};
    end

    // Carry, nibble carry and sign-based overflow at the selected lane width.
    always_comb begin
        sum       = full[W-1:0];
        carry     = wide ? full[W] : full[HW];
        nib_carry = a[4] ^ b[4] ^ full[4];
        sa        = wide ? a[W-1]    : a[HW-1];
        sb        = wide ? b[W-1]    : b[HW-1];
        sr        = wide ? full[W-1] : full[HW-1];
        if (sub) ovf = (sa != sb) && (sr != sa);
        else     ovf = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/alu_logic_shift.sv
// Bitwise operations and one-bit logical shifts, with the shifted-out bit and the
// shift overflow indication. Assumes operand bits above the selected width are zero.
module alu_logic_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         wide,
    output logic [W-1:0] res,
    output logic         shift_out,
    output logic         shift_ovf
);
    import alu_flags_pkg::*;
    localparam int HW = W / 2;

    logic a_top;
    logic [W-1:0] shl;

    // Top bit of the operand and its left-shifted form at the selected width.
    always_comb begin
        a_top = wide ? a[W-1] : a[HW-1];
        shl   = {a[W-2:0], 1'b0};
    end

    // Select the bitwise or shift result and the bit leaving the lane.
    always_comb begin
        res       = '0;
        shift_out = 1'b0;
        shift_ovf = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res       = shl;
                shift_out = a_top;
                shift_ovf = (wide ? shl[W-1] : shl[HW-1]) ^ a_top;
            end
            OP_SHR: begin
                res       = {1'b0, a[W-1:1]};
                shift_out = a[0];
                shift_ovf = a_top;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_status_gen.sv
// Result-derived flags: sign, zero and low-byte parity.
// Assumes the result is already masked to the selected width.
module alu_status_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    input  logic         wide,
    output logic         sgn,
    output logic         zro,
    output logic         par
);
    localparam int HW = W / 2;

    // Sign from the lane top bit, zero over the whole word, even parity over bits 7:0.
    always_comb begin
        sgn = wide ? res[W-1] : res[HW-1];
        zro = (res == '0);
        par = ~^res[7:0];
    end
endmodule

// File: rtl/alu_flags_unit.sv
// Dual-width ALU top: masks operands to the selected width, picks the result,
// builds the six status flags per operation class and holds them in a register
// written under flag_we. Synchronous active-low reset clears the flags.
module alu_flags_unit #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [3:0]    op_code,
    input  logic          wide,
    input  logic          flag_we,
    output logic [W-1:0]  result,
    output logic [5:0]    flags
);
    import alu_flags_pkg::*;
    localparam int HW = W / 2;
    localparam logic [W-1:0] NARROW_MASK = {{(W-HW){1'b0}}, {HW{1'b1}}};

    logic [W-1:0] lane_mask, a_m, b_m, b_arith;
    logic         is_sub, is_arith, is_logic, is_shift, writes;
    logic [W-1:0] as_sum, ls_res, res_m;
    logic         as_cry, as_nib, as_ovf, sh_out, sh_ovf;
    logic         st_sgn, st_zro, st_par;
    alu_flags_t   cur, nxt;

    // Operand masking and operation-class decode.
    always_comb begin
        lane_mask = wide ? '1 : NARROW_MASK;
        a_m       = op_a & lane_mask;
        b_m       = op_b & lane_mask;
        is_arith  = (op_code == OP_ADD) || (op_code == OP_SUB) ||
                    (op_code == OP_INC) || (op_code == OP_DEC);
        is_sub    = (op_code == OP_SUB) || (op_code == OP_DEC);
        is_logic  = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
        is_shift  = (op_code == OP_SHL) || (op_code == OP_SHR);
        writes    = is_arith || is_logic || is_shift;
        b_arith   = ((op_code == OP_INC) || (op_code == OP_DEC)) ? {{(W-1){1'b0}}, 1'b1} : b_m;
    end

    alu_addsub #(.W(W)) i_addsub (
        .a(a_m), .b(b_arith), .sub(is_sub), .wide(wide),
        .sum(as_sum), .carry(as_cry), .nib_carry(as_nib), .ovf(as_ovf)
    );

    alu_logic_shift #(.W(W)) i_logic (
        .a(a_m), .b(b_m), .op(op_code), .wide(wide),
        .res(ls_res), .shift_out(sh_out), .shift_ovf(sh_ovf)
    );

    // Result selection masked to the lane width.
    always_comb begin
        res_m = (is_arith ? as_sum : ls_res) & lane_mask;
    end

    alu_status_gen #(.W(W)) i_status (
        .res(res_m), .wide(wide), .sgn(st_sgn), .zro(st_zro), .par(st_par)
    );

    // Next flag set by operation class.
    always_comb begin
        cur     = alu_flags_t'(flags);
        nxt     = cur;
        nxt.sgn = st_sgn;
        nxt.zro = st_zro;
        nxt.par = st_par;
        if (is_arith) begin
            nxt.nib = as_nib;
            nxt.ovf = as_ovf;
            nxt.cry = ((op_code == OP_INC) || (op_code == OP_DEC)) ? cur.cry : as_cry;
        end else if (is_shift) begin
            nxt.nib = 1'b0;
            nxt.ovf = sh_ovf;
            nxt.cry = sh_out;
        end else begin
            nxt.nib = 1'b0;
            nxt.ovf = 1'b0;
            nxt.cry = 1'b0;
        end
    end

    // Flag register: cleared by reset, written when enabled and the code updates flags.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flags <= '0;
        else if (flag_we && writes) flags <= nxt;
    end

    assign result = res_m;
endmodule

// File: rtl/alu_flags_chk.sv
// Checker for the dual-width ALU, bound to every instance of the top module.
module alu_flags_chk #(
    parameter int W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_code,
    input logic          wide,
    input logic          flag_we,
    input logic [W-1:0]  result,
    input logic [5:0]    flags
);
    localparam int HW = W / 2;

    logic wr_op;
    always_comb wr_op = (op_code <= 4'd6) || (op_code == 4'd8) || (op_code == 4'd9);

    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> flags == 6'd0);

    a_r11_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

    a_r11_complement_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_code == 4'd7) |=> $stable(flags));

    a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_code == 4'd2 || op_code == 4'd3 || op_code == 4'd4))
        |=> (flags[0] == 1'b0 && flags[5] == 1'b0 && flags[2] == 1'b0));

    a_r9_incdec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_code == 4'd5 || op_code == 4'd6)) |=> $stable(flags[0]));

    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wr_op) |=> flags[3] == ($past(result) == '0));

    a_r2_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wr_op) |=> flags[4] == $past(wide ? result[W-1] : result[HW-1]));

    a_r4_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wr_op) |=> flags[1] == ~^$past(result[7:0]));

    a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> result[W-1:HW] == '0);
endmodule

bind alu_flags_unit alu_flags_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .wide(wide),
    .flag_we(flag_we), .result(result), .flags(flags)
);

// File: tb/test_alu_flags_unit.sv
`timescale 1ns/1ps
module test_alu_flags_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [3:0]  op_code = '0;
    logic        wide = 1'b0, flag_we = 1'b0;
    logic [15:0] result;
    logic [5:0]  flags;

    int checks = 0;
    int errors = 0;
    logic [5:0] model_flags = '0;

    always #10 clk = ~clk;

    alu_flags_unit i_alu_flags_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .wide(wide), .flag_we(flag_we), .result(result), .flags(flags)
    );

    function automatic int sx(int v, int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    // Reference: expected result and flags from integer arithmetic.
    task automatic model(input int op, input int ain, input int bin, input bit wd,
                         input bit we, output int r, inout logic [5:0] f);
        int w, m, half, a, b, s, sr;
        bit cf, af, of, wr;
        w = wd ? 16 : 8; m = (1 << w) - 1; half = 1 << (w - 1);
        a = ain & m; b = bin & m;
        cf = f[0]; af = 0; of = 0; wr = 1; r = 0;
        case (op)
            0, 5: begin
                if (op == 5) b = 1;
                s = a + b; r = s & m;
                if (op == 0) cf = (s > m);
                af = ((a & 15) + (b & 15)) > 15;
                sr = sx(a, w) + sx(b, w); of = (sr < -half) || (sr >= half);
            end
            1, 6: begin
                if (op == 6) b = 1;
                r = (a - b) & m;
                if (op == 1) cf = (a < b);
                af = (a & 15) < (b & 15);
                sr = sx(a, w) - sx(b, w); of = (sr < -half) || (sr >= half);
            end
            2: begin r = a & b; cf = 0; end
            3: begin r = a | b; cf = 0; end
            4: begin r = a ^ b; cf = 0; end
            7: begin r = (~a) & m; wr = 0; end
            8: begin r = (a << 1) & m; cf = (a >> (w - 1)) & 1; of = ((r >> (w - 1)) & 1) ^ cf; end
            9: begin r = a >> 1; cf = a & 1; of = (a >> (w - 1)) & 1; end
            default: begin r = 0; wr = 0; end
        endcase
        if (we && wr) begin
            f[0] = cf;
            f[1] = ($countones(r & 255) % 2) == 0;
            f[2] = af;
            f[3] = (r == 0);
            f[4] = (r >> (w - 1)) & 1;
            f[5] = of;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h wide=%0b actual=%h expected=%h",
                     tag, op_code, op_a, op_b, wide, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, check result, then flags after the edge.
    task automatic apply(input int op, input int a, input int b, input bit wd, input bit we);
        int r;
        @(negedge clk);
        op_code = op[3:0]; op_a = a[15:0]; op_b = b[15:0]; wide = wd; flag_we = we;
        model(op, a, b, wd, we, r, model_flags);
        #2;
        chk("R1 result", int'(result), r);
        @(posedge clk);
        #5;
        chk("R5 R8 R9 R10 R11 carry", flags[0], model_flags[0]);
        chk("R4 parity", flags[1], model_flags[1]);
        chk("R6 R8 R10 nibble", flags[2], model_flags[2]);
        chk("R3 zero", flags[3], model_flags[3]);
        chk("R2 sign", flags[4], model_flags[4]);
        chk("R7 R8 R10 R11 overflow", flags[5], model_flags[5]);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; flag_we = 1'b0;
        @(posedge clk); #5;
        model_flags = '0;
        chk("R12 reset flags", flags, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int corner [12] = '{16'h0000, 16'h0001, 16'h000F, 16'h0010, 16'h007F, 16'h0080,
                            16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
        repeat (3) @(posedge clk);
        do_reset();
        // Sweep 8-bit add and subtract over every a and a spread of b (R5 R6 R7).
        for (int op = 0; op < 2; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 17)
                    apply(op, a, b, 1'b0, 1'b1);
        // Sweep 8-bit unary, logic and shift operations; vary the enable (R9 R10 R11).
        for (int op = 2; op < 16; op++)
            for (int a = 0; a < 256; a++)
                apply(op, a, (a * 37 + 11) & 255, 1'b0, ((a + op) % 5) != 0);
        // Upper operand byte must be ignored in 8-bit mode (R1).
        for (int a = 0; a < 256; a += 5)
            apply(0, 16'hA500 | a, 16'h5A00 | (255 - a), 1'b0, 1'b1);
        // 16-bit corner pairs for all operations (R4 parity on low byte only).
        for (int op = 0; op < 11; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    apply(op, corner[i], corner[j], 1'b1, 1'b1);
        // Complement after a flag-setting op leaves flags intact (R11).
        apply(1, 0, 1, 1'b1, 1'b1);
        apply(7, 16'h1234, 0, 1'b1, 1'b1);
        // Increment keeps a set carry (R9).
        apply(5, 16'hFFFF, 0, 1'b1, 1'b1);
        do_reset();
        apply(0, 16'h7FFF, 1, 1'b1, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule